// File: doc/BRIEF.md
# Receive Frame Page Formatter

This block turns an incoming Ethernet frame, presented one byte per beat, into a packet page in the controller's buffer layout. A page holds a two-byte status word, a two-byte byte count, the frame data, zero padding for short frames, an optional four-byte CRC and a two-byte control trailer. The trailer tells software whether the stored frame ends on an odd byte. Data bytes go into the page RAM as they arrive. The status and count go in last, in a second write pass, because the frame length is only known once the last byte has been seen.

The receive enables, the soft-reset flag and the CRC-strip option are sampled on the first byte of each frame. The page to fill comes from the allocator's grant on that same beat, and the allocator holds it until the frame ends. When a frame completes, the block pushes its page number onto the receive queue and pulses the receive-interrupt set line. A frame that cannot be taken is consumed to its end and then reported with a one-cycle drop pulse. Between the last byte and the push or drop, the block holds its stream ready low.

Top module: `rxfmt_top`

## Requirements
- R1: A frame whose first byte arrives while `rx_enable_i` is low, `soft_reset_i` is high or `page_vld_i` is low is consumed to its last byte. It then gives one `drop_o` pulse, with no RAM write and no push.
- R2: For a frame of L bytes, D is 64 if L < 64 and L rounded down to even otherwise. The stored count is D + 6, plus 4 when `strip_crc_i` is low. It is written little-endian at page bytes 2 and 3.
- R3: A frame whose count exceeds 2048 is dropped with one `drop_o` pulse and is never pushed.
- R4: The status word is written little-endian at page bytes 0 and 1. Bit 11 is set when L > 1518 and bit 12 is set when L is odd; every other bit is zero.
- R5: Frame byte i lands at page byte 4 + i for the D data bytes. For L < 64, page bytes 4 + L through 67 are zero.
- R6: When `strip_crc_i` is low, page bytes 4 + D through 7 + D hold the Ethernet CRC-32, least-significant byte first. It uses the reflected polynomial 0xEDB88320, an all-ones start and a final inversion. It covers the frame bytes, plus the zero padding when L < 64.
- R7: The two trailer bytes follow the data, or the CRC when it is kept. For L >= 64 with L odd they are the last frame byte and then 0x60. In every other case they are 0x00 and then 0x40.
- R8: An accepted frame gives one single-cycle `rxq_push_o` with `rxq_page_o` equal to the granted page. `rx_int_o` pulses in the same cycle, and a push never coincides with a drop.
- R9: `frm_ready_o` is high out of reset and while a frame streams in. It is low from the cycle after an accepted frame's last byte until the push or drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_enable_i | input | 1 | Receive enable from the receive control register |
| soft_reset_i | input | 1 | Soft reset flag from the receive control register |
| strip_crc_i | input | 1 | High to leave the CRC out of the page |
| page_vld_i | input | 1 | Allocator has a free page granted |
| page_i | input | 2 | Granted page number |
| frm_valid_i | input | 1 | Frame byte valid |
| frm_data_i | input | 8 | Frame byte |
| frm_last_i | input | 1 | Marks the final byte of the frame |
| frm_ready_o | output | 1 | Block accepts a frame byte |
| ram_we_o | output | 1 | Page RAM write enable |
| ram_page_o | output | 2 | Page RAM page select |
| ram_addr_o | output | 11 | Byte address within the page |
| ram_wdata_o | output | 8 | Page RAM write data |
| rxq_push_o | output | 1 | Push a page onto the receive queue |
| rxq_page_o | output | 2 | Page number being pushed |
| rx_int_o | output | 1 | Pulse that sets the receive interrupt bit |
| drop_o | output | 1 | Frame rejected |

## Verification
The hardest place to reach is the count limit. Only frames of about two thousand bytes come near it, and the limit moves by four bytes with the CRC option. The stimulus sends every length from 2038 to 2045 in both CRC modes, which lands on each side of the limit.

The odd-length cases are the other hard area: the CRC sits before the odd byte, and short frames are padded. They are reached by sweeping every length from 1 to 130 in both modes, with idle gaps inside some frames. The lengths 1515 to 1522 cover the long-frame status bit.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_STRM, S_DROP, S_EVAL, S_PAD, S_CRC, S_TRL, S_HDR
  } rx_state_e;

  localparam logic [7:0]  TRL_ODD  = 8'h60;
  localparam logic [7:0]  TRL_EVEN = 8'h40;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

endpackage

// File: rtl/rxfmt_crc.sv
module rxfmt_crc import rxfmt_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q, base;

  assign base = init_i ? '1 : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (en_i)   crc_q <= crc_step(base, byte_i);
    else if (init_i) crc_q <= '1;
  end

  assign crc_o = ~crc_q;

  // R6: crc only moves on a counted byte
  assert_crc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !init_i) |=> $stable(crc_q));

endmodule

// File: rtl/rxfmt_len.sv
module rxfmt_len #(
  parameter int unsigned LW         = 13,
  parameter int unsigned CW         = 14,
  parameter int unsigned MIN_FRAME  = 64,
  parameter int unsigned LONG_LIMIT = 1518,
  parameter int unsigned PAGE_BYTES = 2048,
  parameter int unsigned HDR_BYTES  = 4,
  parameter int unsigned CRC_BYTES  = 4,
  parameter int unsigned TRL_BYTES  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          keep_crc_i,
  output logic [LW-1:0] len_o,
  output logic [CW-1:0] data_bytes_o,
  output logic [CW-1:0] count_o,
  output logic          short_o,
  output logic          odd_o,
  output logic          long_o,
  output logic          too_big_o
);
  localparam logic [LW-1:0] LEN_MAX = '1;

  logic [LW-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        len_q <= '0;
    else if (clr_i)                     len_q <= inc_i ? LW'(1) : '0;
    else if (inc_i && len_q != LEN_MAX) len_q <= len_q + LW'(1);
  end

  assign len_o        = len_q;
  assign short_o      = len_q < LW'(MIN_FRAME);
  assign odd_o        = len_q[0];
  assign long_o       = len_q > LW'(LONG_LIMIT);
  assign data_bytes_o = short_o ? CW'(MIN_FRAME) : CW'({len_q[LW-1:1], 1'b0});
  assign count_o      = data_bytes_o + CW'(HDR_BYTES + TRL_BYTES)
                      + (keep_crc_i ? CW'(CRC_BYTES) : CW'(0));
  assign too_big_o    = count_o > CW'(PAGE_BYTES);

  // R2: length counter saturates, never wraps
  assert_len_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q == LEN_MAX && !clr_i) |=> len_q == LEN_MAX);

endmodule

// File: rtl/rxfmt_ctrl.sv
module rxfmt_ctrl import rxfmt_pkg::*; #(
  parameter int unsigned PAGE_BYTES = 2048,
  parameter int unsigned MIN_FRAME  = 64,
  parameter int unsigned HDR_BYTES  = 4,
  parameter int unsigned AW         = 11,
  parameter int unsigned PW         = 2,
  parameter int unsigned LW         = 13,
  parameter int unsigned CW         = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_enable_i,
  input  logic          soft_reset_i,
  input  logic          strip_crc_i,
  input  logic          page_vld_i,
  input  logic [PW-1:0] page_i,
  input  logic          frm_valid_i,
  input  logic [7:0]    frm_data_i,
  input  logic          frm_last_i,
  output logic          frm_ready_o,
  input  logic [LW-1:0] len_i,
  input  logic [CW-1:0] data_bytes_i,
  input  logic [CW-1:0] count_i,
  input  logic          short_i,
  input  logic          odd_i,
  input  logic          long_i,
  input  logic          too_big_i,
  input  logic [31:0]   crc_i,
  output logic          len_clr_o,
  output logic          len_inc_o,
  output logic          crc_init_o,
  output logic          crc_en_o,
  output logic [7:0]    crc_byte_o,
  output logic          keep_crc_o,
  output logic          ram_we_o,
  output logic [PW-1:0] ram_page_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  output logic          push_o,
  output logic [PW-1:0] push_page_o,
  output logic          drop_o
);
  localparam logic [AW-1:0] PAD_END = AW'(HDR_BYTES + MIN_FRAME - 1);

  rx_state_e     state_q;
  logic [PW-1:0] page_q;
  logic [AW-1:0] a_q;
  logic [1:0]    k_q;
  logic [7:0]    last_q;
  logic          keep_q, push_q, drop_q;
  logic          beat, start_ok, in_rng, odd_long;
  logic [LW-1:0] stream_addr;
  logic [15:0]   cnt16;

  assign frm_ready_o = state_q inside {S_IDLE, S_STRM, S_DROP};
  assign beat        = frm_valid_i && frm_ready_o;
  assign start_ok    = rx_enable_i && !soft_reset_i && page_vld_i;
  assign stream_addr = LW'(HDR_BYTES) + len_i;
  assign in_rng      = stream_addr < LW'(PAGE_BYTES);
  assign odd_long    = odd_i && !short_i;
  assign cnt16       = 16'(count_i);

  always_comb begin
    ram_we_o    = 1'b0;
    ram_addr_o  = '0;
    ram_wdata_o = '0;
    len_clr_o   = 1'b0;
    len_inc_o   = 1'b0;
    crc_init_o  = 1'b0;
    crc_en_o    = 1'b0;
    crc_byte_o  = frm_data_i;
    ram_page_o  = (state_q == S_IDLE) ? page_i : page_q;
    unique case (state_q)
      S_IDLE: if (beat && start_ok) begin
        ram_we_o    = 1'b1;
        ram_addr_o  = AW'(HDR_BYTES);
        ram_wdata_o = frm_data_i;
        len_clr_o   = 1'b1;
        len_inc_o   = 1'b1;
        crc_init_o  = 1'b1;
        crc_en_o    = 1'b1;
      end
      S_STRM: if (beat) begin
        ram_we_o    = in_rng;
        ram_addr_o  = AW'(stream_addr);
        ram_wdata_o = frm_data_i;
        len_inc_o   = 1'b1;
        crc_en_o    = 1'b1;
      end
      S_PAD: begin
        ram_we_o   = 1'b1;
        ram_addr_o = a_q;
        crc_en_o   = 1'b1;
        crc_byte_o = 8'h00;
      end
      S_CRC: begin
        ram_we_o    = 1'b1;
        ram_addr_o  = a_q;
        ram_wdata_o = crc_i[8*k_q +: 8];
      end
      S_TRL: begin
        ram_we_o    = 1'b1;
        ram_addr_o  = a_q;
        ram_wdata_o = k_q[0] ? (odd_long ? TRL_ODD : TRL_EVEN)
                             : (odd_long ? last_q : 8'h00);
      end
      S_HDR: begin
        ram_we_o   = 1'b1;
        ram_addr_o = AW'(k_q);
        unique case (k_q)
          2'd0:    ram_wdata_o = 8'h00;
          2'd1:    ram_wdata_o = {3'b000, odd_i, long_i, 3'b000};
          2'd2:    ram_wdata_o = cnt16[7:0];
          default: ram_wdata_o = cnt16[15:8];
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      page_q  <= '0;
      a_q     <= '0;
      k_q     <= '0;
      last_q  <= '0;
      keep_q  <= 1'b0;
      push_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      push_q <= 1'b0;
      drop_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (beat) begin
          if (start_ok) begin
            page_q  <= page_i;
            keep_q  <= !strip_crc_i;
            last_q  <= frm_data_i;
            state_q <= frm_last_i ? S_EVAL : S_STRM;
          end else if (frm_last_i) begin
            drop_q <= 1'b1;
          end else begin
            state_q <= S_DROP;
          end
        end
        S_DROP: if (beat && frm_last_i) begin
          drop_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        S_STRM: if (beat) begin
          last_q <= frm_data_i;
          if (frm_last_i) state_q <= S_EVAL;
        end
        S_EVAL: begin
          k_q <= '0;
          if (too_big_i) begin
            drop_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (short_i) begin
            a_q     <= AW'(HDR_BYTES) + AW'(len_i);
            state_q <= S_PAD;
          end else begin
            a_q     <= AW'(HDR_BYTES) + AW'(data_bytes_i);
            state_q <= keep_q ? S_CRC : S_TRL;
          end
        end
        S_PAD: begin
          a_q <= a_q + AW'(1);
          if (a_q == PAD_END) state_q <= keep_q ? S_CRC : S_TRL;
        end
        S_CRC: begin
          a_q <= a_q + AW'(1);
          k_q <= k_q + 2'd1;
          if (k_q == 2'd3) state_q <= S_TRL;
        end
        S_TRL: begin
          a_q <= a_q + AW'(1);
          k_q <= k_q + 2'd1;
          if (k_q == 2'd1) begin
            k_q     <= '0;
            state_q <= S_HDR;
          end
        end
        S_HDR: begin
          k_q <= k_q + 2'd1;
          if (k_q == 2'd3) begin
            push_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign keep_crc_o  = keep_q;
  assign push_o      = push_q;
  assign push_page_o = page_q;
  assign drop_o      = drop_q;

  assert_no_write_drop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DROP) |-> !ram_we_o);

  assert_no_push_oversize_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_q |-> !$past(too_big_i));

  assert_push_drop_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_q && drop_q));

  assert_push_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_q |=> !push_q);

  assert_busy_after_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STRM && beat && frm_last_i) |=> !frm_ready_o);

endmodule

// File: rtl/rxfmt_top.sv
module rxfmt_top #(
  parameter int unsigned PAGE_BYTES = 2048,
  parameter int unsigned N_PAGES    = 4,
  parameter int unsigned MIN_FRAME  = 64,
  parameter int unsigned LONG_LIMIT = 1518,
  localparam int unsigned AW = $clog2(PAGE_BYTES),
  localparam int unsigned PW = $clog2(N_PAGES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_enable_i,
  input  logic          soft_reset_i,
  input  logic          strip_crc_i,
  input  logic          page_vld_i,
  input  logic [PW-1:0] page_i,
  input  logic          frm_valid_i,
  input  logic [7:0]    frm_data_i,
  input  logic          frm_last_i,
  output logic          frm_ready_o,
  output logic          ram_we_o,
  output logic [PW-1:0] ram_page_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  output logic          rxq_push_o,
  output logic [PW-1:0] rxq_page_o,
  output logic          rx_int_o,
  output logic          drop_o
);
  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned CRC_BYTES = 4;
  localparam int unsigned TRL_BYTES = 2;
  localparam int unsigned LW        = AW + 2;
  localparam int unsigned CW        = LW + 1;

  logic [LW-1:0] len;
  logic [CW-1:0] data_bytes, count;
  logic          short_f, odd_f, long_f, too_big;
  logic          len_clr, len_inc, keep_crc;
  logic          crc_init, crc_en;
  logic [7:0]    crc_byte;
  logic [31:0]   crc;
  logic          push;

  rxfmt_len #(
    .LW(LW), .CW(CW), .MIN_FRAME(MIN_FRAME), .LONG_LIMIT(LONG_LIMIT),
    .PAGE_BYTES(PAGE_BYTES), .HDR_BYTES(HDR_BYTES), .CRC_BYTES(CRC_BYTES),
    .TRL_BYTES(TRL_BYTES)
  ) u_len (
    .clk_i, .rst_ni,
    .clr_i(len_clr), .inc_i(len_inc), .keep_crc_i(keep_crc),
    .len_o(len), .data_bytes_o(data_bytes), .count_o(count),
    .short_o(short_f), .odd_o(odd_f), .long_o(long_f), .too_big_o(too_big)
  );

  rxfmt_crc u_crc (
    .clk_i, .rst_ni,
    .init_i(crc_init), .en_i(crc_en), .byte_i(crc_byte), .crc_o(crc)
  );

  rxfmt_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .MIN_FRAME(MIN_FRAME), .HDR_BYTES(HDR_BYTES),
    .AW(AW), .PW(PW), .LW(LW), .CW(CW)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .rx_enable_i, .soft_reset_i, .strip_crc_i, .page_vld_i, .page_i,
    .frm_valid_i, .frm_data_i, .frm_last_i, .frm_ready_o,
    .len_i(len), .data_bytes_i(data_bytes), .count_i(count),
    .short_i(short_f), .odd_i(odd_f), .long_i(long_f), .too_big_i(too_big),
    .crc_i(crc),
    .len_clr_o(len_clr), .len_inc_o(len_inc),
    .crc_init_o(crc_init), .crc_en_o(crc_en), .crc_byte_o(crc_byte),
    .keep_crc_o(keep_crc),
    .ram_we_o, .ram_page_o, .ram_addr_o, .ram_wdata_o,
    .push_o(push), .push_page_o(rxq_page_o), .drop_o
  );

  assign rxq_push_o = push;
  assign rx_int_o   = push;

endmodule

// File: tb/tb_rxfmt_top.sv
`timescale 1ns/1ps
module tb_rxfmt_top;
  localparam int PB = 2048;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       rx_en = 1'b0, srst = 1'b0, strip = 1'b0, pvld = 1'b0;
  logic [1:0] pg = '0;
  logic       fv = 1'b0, fl = 1'b0;
  logic [7:0] fd = '0;
  logic        frdy, we, push, rint, drop;
  logic [1:0]  wpage, ppage;
  logic [10:0] waddr;
  logic [7:0]  wdata;

  rxfmt_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_enable_i(rx_en), .soft_reset_i(srst), .strip_crc_i(strip),
    .page_vld_i(pvld), .page_i(pg),
    .frm_valid_i(fv), .frm_data_i(fd), .frm_last_i(fl), .frm_ready_o(frdy),
    .ram_we_o(we), .ram_page_o(wpage), .ram_addr_o(waddr), .ram_wdata_o(wdata),
    .rxq_push_o(push), .rxq_page_o(ppage), .rx_int_o(rint), .drop_o(drop)
  );

  logic [7:0] mem [NP][PB];
  int wr_cnt = 0;
  always @(posedge clk) if (we) begin
    mem[wpage][waddr] <= wdata;
    wr_cnt <= wr_cnt + 1;
  end

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual %0d cycles expected < 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int len, input int i);
    return 8'((i * 29 + len * 3 + 5) ^ (i >> 3));
  endfunction

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int j = 0; j < 8; j++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic send(input int len, input bit gap);
    for (int i = 0; i < len; i++) begin
      if (gap && (i % 4 == 2)) begin
        fv = 1'b0;
        @(negedge clk);
      end
      while (!frdy) @(negedge clk);
      fv = 1'b1; fd = fb(len, i); fl = (i == len - 1);
      @(negedge clk);
    end
    fv = 1'b0; fl = 1'b0;
  endtask

  task automatic wait_done(output bit p, output bit d, output int pp, output int leak);
    p = 0; d = 0; pp = -1; leak = 0;
    for (int t = 0; t < 6000; t++) begin
      if (push || drop) begin
        p = push; d = drop; pp = int'(ppage);
        check(rint == push, "R8", "interrupt pulse with push", rint, push);
        break;
      end
      if (frdy) leak++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic check_image(input int len, input bit keep, input int pn);
    bit sh, ol;
    int d, cnt, bad, t0;
    logic [31:0] c, act_crc;
    logic [15:0] st, act_st, act_cnt, exp_trl, act_trl;
    logic [7:0] e;
    sh = len < 64;
    d = sh ? 64 : (len & ~1);
    cnt = d + 6 + (keep ? 4 : 0);
    ol = !sh && (len % 2 == 1);
    st = 16'((len > 1518 ? 16'h0800 : 16'h0) | (len % 2 == 1 ? 16'h1000 : 16'h0));
    act_st = {mem[pn][1], mem[pn][0]};
    check(act_st == st, "R4", $sformatf("status len %0d", len), act_st, st);
    act_cnt = {mem[pn][3], mem[pn][2]};
    check(act_cnt == 16'(cnt), "R2", $sformatf("count len %0d crc %0d", len, keep), act_cnt, cnt);
    bad = 0;
    for (int i = 0; i < d; i++) begin
      e = (i < len) ? fb(len, i) : 8'h00;
      if (mem[pn][4 + i] != e) bad++;
    end
    if (cnt < PB && mem[pn][cnt] != 8'hA5) bad++;
    check(bad == 0, "R5", $sformatf("data/pad bytes wrong, len %0d", len), bad, 0);
    if (keep) begin
      c = 32'hFFFFFFFF;
      for (int i = 0; i < (sh ? 64 : len); i++) c = crc_upd(c, (i < len) ? fb(len, i) : 8'h00);
      c = ~c;
      act_crc = {mem[pn][4 + d + 3], mem[pn][4 + d + 2], mem[pn][4 + d + 1], mem[pn][4 + d]};
      check(act_crc == c, "R6", $sformatf("crc len %0d", len), act_crc, c);
    end
    t0 = 4 + d + (keep ? 4 : 0);
    exp_trl = ol ? {8'h60, fb(len, len - 1)} : 16'h4000;
    act_trl = {mem[pn][t0 + 1], mem[pn][t0]};
    check(act_trl == exp_trl, "R7", $sformatf("trailer len %0d crc %0d", len, keep), act_trl, exp_trl);
  endtask

  // exp_acc: 1 accepted, 0 dropped; start_rej: drop decided at first byte
  task automatic run(input int len, input bit strip_m, input bit gap,
                     input bit en, input bit sr, input bit pv,
                     input bit exp_acc, input bit start_rej, input string rq);
    bit p, d;
    int pp, leak, pn, w0;
    pn = len % NP;
    for (int a = 0; a < PB; a++) mem[pn][a] = 8'hA5;
    rx_en = en; srst = sr; strip = strip_m; pvld = pv; pg = 2'(pn);
    w0 = wr_cnt;
    send(len, gap);
    wait_done(p, d, pp, leak);
    check(p == exp_acc && d == !exp_acc, rq, $sformatf("push/drop len %0d crc %0d", len, !strip_m),
          {p, d}, {exp_acc, !exp_acc});
    if (!start_rej)
      check(leak == 0, "R9", $sformatf("ready high after last, len %0d", len), leak, 0);
    if (exp_acc) begin
      check(pp == pn, "R8", $sformatf("pushed page len %0d", len), pp, pn);
      check_image(len, !strip_m, pn);
    end
    if (start_rej)
      check(wr_cnt == w0, "R1", $sformatf("writes on rejected frame len %0d", len), wr_cnt - w0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(frdy == 1'b1, "R9", "ready after reset", frdy, 1);
    check(push == 1'b0 && drop == 1'b0, "R8", "no pulse after reset", {push, drop}, 0);
    check(we == 1'b0, "R1", "no write after reset", we, 0);

    // R1: rejection at the first byte
    run(10, 0, 0, 0, 0, 1, 0, 1, "R1");
    run(1,  0, 0, 0, 0, 1, 0, 1, "R1");
    run(10, 0, 1, 1, 1, 1, 0, 1, "R1");
    run(1,  1, 0, 1, 1, 1, 0, 1, "R1");
    run(12, 0, 0, 1, 0, 0, 0, 1, "R1");
    run(1,  0, 0, 1, 0, 0, 0, 1, "R1");

    // R5 R6 R7: length sweep across the short/long edge, both CRC modes
    for (int l = 1; l <= 130; l++) begin
      run(l, 0, (l % 3 == 0), 1, 0, 1, 1, 0, "R8");
      run(l, 1, (l % 3 == 1), 1, 0, 1, 1, 0, "R8");
    end

    // R4: long-frame status bit
    for (int l = 1515; l <= 1522; l++) run(l, (l % 2 == 0), 0, 1, 0, 1, 1, 0, "R4");

    // R3: count limit; kept crc drops at 2040+, stripped at 2044+
    for (int l = 2038; l <= 2045; l++) begin
      run(l, 0, 0, 1, 0, 1, (l < 2040), 0, "R3");
      run(l, 1, 0, 1, 0, 1, (l < 2044), 0, "R3");
    end

    // R1: block recovers after a drop
    run(5, 0, 0, 0, 0, 1, 0, 1, "R1");
    run(70, 0, 1, 1, 0, 1, 1, 0, "R1");

    summary();
    $finish;
  end

endmodule